// File: doc/BRIEF.md
# Framed Cell Bus Transmitter

This block is the sending side of one station on a shared 32-bit cell bus. The bus runs in fixed frames of 16 clock cycles. Cycle 0 is the request slot. Cycles 1 to 14 carry one cell. Cycle 15 carries the grant from the arbiter, and in that same cycle the current sender drives a parity word.

While a cell is waiting in the local buffer, the station raises its own request line in cycle 0. If the arbiter names this station in cycle 15, the station owns the next frame. In that frame it drives the following words, in order:
- the routing word;
- the packed cell header;
- twelve payload words;
- a bit-interleaved even-parity word computed over those fourteen words.

When the frame ends, the station hands the cell back to the buffer.

A frame-start input re-aligns the free-running cycle counter. A re-alignment that lands inside a granted frame stops the transmission and leaves the cell waiting.

Top module: `cellbus_tx`

## Requirements
- R1: The cycle number `cyc_o` is 0 during reset and after reset counts 0 to 15 and wraps. The cycle after any cycle with `frame_start_i` high is cycle 0.
- R2: `req_o` is all zeros outside cycle 0. In cycle 0 it has exactly bit `dev_id_i` set when `cell_valid_i` was high in the cycle before, except in the cases named in R8.
- R3: The station transmits only in the frame that follows a cycle 15 in which three things held: `grant_valid_i` was high, `grant_id_i` equalled `dev_id_i`, and the station had requested in cycle 0 of that frame. A matching grant without a preceding request, or a grant naming another station, has no effect.
- R4: `bus_oe_o` is high exactly in cycles 1 to 15 of a transmitting frame. `bus_data_o` is zero whenever `bus_oe_o` is low.
- R5: In a transmitting frame, cycle 1 carries `route_i`. Cycle 2 carries the header with `vpi_i` in bits 31:20, `vci_i` in bits 19:4, `pti_i` in bits 3:1 and `clp_i` in bit 0. Cycles 3 to 14 carry payload words 0 to 11.
- R6: During cycles 2 to 13, `pay_idx_o` equals the cycle number minus 2 and `pay_data_i` is read in that same cycle. Payload word k holds bytes 4k to 4k+3, with byte 4k in bits 31:24. This word is passed unchanged to the bus in the next cycle.
- R7: In cycle 15 of a transmitting frame, bit i of `bus_data_o` is the XOR of bit i of the fourteen words driven in cycles 1 to 14 (even parity).
- R8: `cell_done_o` pulses for one cycle in cycle 0 right after a transmitting frame that completed cycle 15. The request is suppressed in that cycle 0 and in cycle 0 of the transmitting frame itself.
- R9: A `frame_start_i` pulse inside a transmitting frame drops `bus_oe_o` in the next cycle and gives no `cell_done_o`. The pending cell is requested again in the new cycle 0.
- R10: While `rst_n` is low, `req_o`, `bus_oe_o`, `bus_data_o` and `cell_done_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Next cycle is cycle 0 of a frame |
| dev_id_i | input | 4 | Station number |
| cell_valid_i | input | 1 | A cell is waiting in the local buffer |
| route_i | input | 32 | Routing word of the waiting cell |
| vpi_i | input | 12 | Path identifier (GFC/VPI) |
| vci_i | input | 16 | Channel identifier |
| pti_i | input | 3 | Payload type |
| clp_i | input | 1 | Cell loss priority |
| pay_idx_o | output | 4 | Payload word index being read |
| pay_data_i | input | 32 | Payload word at `pay_idx_o` |
| grant_valid_i | input | 1 | Grant present (sampled in cycle 15) |
| grant_id_i | input | 4 | Granted station number |
| req_o | output | 16 | Request lines, one per station |
| bus_data_o | output | 32 | Cell bus data |
| bus_oe_o | output | 1 | Bus output enable |
| cell_done_o | output | 1 | Cell released to the buffer |
| cyc_o | output | 4 | Current cycle number in the frame |

## Verification
A wrong cycle count shifts every later word. That shows at once as a header or payload word in the wrong cycle, and as a request outside cycle 0. A corrupted grant or transmit flag shows one cycle after cycle 15: either `bus_oe_o` rises in a frame with no valid grant, or it stays low in a frame that had one. A bad parity accumulator is visible only in cycle 15 of a transmitting frame, so every station's frame compares that word against a bench-computed XOR of the fourteen words sent before it.

// File: rtl/cb_pkg.sv
`timescale 1ns/1ps
package cb_pkg;
  // Fixed slot positions inside a frame; the receivers decode by cycle.
  localparam int REQ_CYC       = 0;
  localparam int ROUTE_CYC     = 1;
  localparam int HDR_CYC       = 2;
  localparam int FIRST_PAY_CYC = 3;

  // Header word, most significant field first.
  typedef struct packed {
    logic [11:0] vpi;
    logic [15:0] vci;
    logic [2:0]  pti;
    logic        clp;
  } cell_hdr_t;
endpackage

// File: rtl/cb_frame_ctr.sv
`timescale 1ns/1ps
module cb_frame_ctr #(
  parameter  int FRAME_LEN = 16,
  localparam int CYC_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic [CYC_W-1:0] cyc_o,
  output logic [CYC_W-1:0] cyc_nxt_o
);
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(FRAME_LEN - 1);

  logic [CYC_W-1:0] cyc_q;
  logic [CYC_W-1:0] cyc_d;

  always_comb begin
    if (start_i)
      cyc_d = '0;
    else if (cyc_q == LAST_CYC)
      cyc_d = '0;
    else
      cyc_d = cyc_q + CYC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_d;
  end

  assign cyc_o     = cyc_q;
  assign cyc_nxt_o = cyc_d;
endmodule

// File: rtl/cb_hdr_pack.sv
`timescale 1ns/1ps
module cb_hdr_pack
  import cb_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic [11:0]      vpi_i,
  input  logic [15:0]      vci_i,
  input  logic [2:0]       pti_i,
  input  logic             clp_i,
  output logic [BUS_W-1:0] word_o
);
  cell_hdr_t hdr;

  always_comb begin
    hdr.vpi = vpi_i;
    hdr.vci = vci_i;
    hdr.pti = pti_i;
    hdr.clp = clp_i;
  end

  generate
    if (BUS_W > $bits(cell_hdr_t)) begin : g_pad
      assign word_o = {{(BUS_W - $bits(cell_hdr_t)){1'b0}}, hdr};
    end else begin : g_exact
      assign word_o = hdr;
    end
  endgenerate
endmodule

// File: rtl/cb_tx_ctrl.sv
`timescale 1ns/1ps
module cb_tx_ctrl
  import cb_pkg::*;
#(
  parameter  int NUM_DEV   = 16,
  parameter  int FRAME_LEN = 16,
  localparam int ID_W      = $clog2(NUM_DEV),
  localparam int CYC_W     = $clog2(FRAME_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CYC_W-1:0]   cyc_i,
  input  logic [CYC_W-1:0]   cyc_nxt_i,
  input  logic [ID_W-1:0]    dev_id_i,
  input  logic               cell_valid_i,
  input  logic               grant_valid_i,
  input  logic [ID_W-1:0]    grant_id_i,
  output logic [NUM_DEV-1:0] req_o,
  output logic               done_o,
  output logic               drive_nxt_o
);
  localparam logic [CYC_W-1:0] C_REQ  = CYC_W'(REQ_CYC);
  localparam logic [CYC_W-1:0] C_LAST = CYC_W'(FRAME_LEN - 1);

  logic [NUM_DEV-1:0] own_line;
  logic [NUM_DEV-1:0] req_q, req_d;
  logic               tx_q, tx_d;
  logic               asked_q, asked_d;
  logic               done_q, done_d;
  logic               wrap, grant_hit;

  generate
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_line
      assign own_line[i] = (dev_id_i == ID_W'(i));
    end
  endgenerate

  always_comb begin
    wrap      = (cyc_nxt_i == C_REQ);
    grant_hit = grant_valid_i && (grant_id_i == dev_id_i) && asked_q
                && (cyc_i == C_LAST);
    done_d    = wrap && tx_q && (cyc_i == C_LAST);
    tx_d      = wrap ? grant_hit : tx_q;
    req_d     = (wrap && cell_valid_i && !grant_hit && !done_d) ? own_line : '0;
    asked_d   = wrap ? (|req_d) : asked_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      tx_q    <= 1'b0;
      asked_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      req_q   <= req_d;
      tx_q    <= tx_d;
      asked_q <= asked_d;
      done_q  <= done_d;
    end
  end

  assign req_o       = req_q;
  assign done_o      = done_q;
  assign drive_nxt_o = tx_d && (cyc_nxt_i != C_REQ);
endmodule

// File: rtl/cb_tx_dp.sv
`timescale 1ns/1ps
module cb_tx_dp
  import cb_pkg::*;
#(
  parameter  int BUS_W     = 32,
  parameter  int FRAME_LEN = 16,
  parameter  int PAY_WORDS = 12,
  localparam int CYC_W     = $clog2(FRAME_LEN),
  localparam int IDX_W     = $clog2(PAY_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CYC_W-1:0] cyc_i,
  input  logic [CYC_W-1:0] cyc_nxt_i,
  input  logic             drive_nxt_i,
  input  logic [BUS_W-1:0] route_i,
  input  logic [BUS_W-1:0] hdr_word_i,
  input  logic [BUS_W-1:0] pay_data_i,
  output logic [IDX_W-1:0] pay_idx_o,
  output logic [BUS_W-1:0] bus_data_o,
  output logic             bus_oe_o
);
  localparam int PAY_HI_CYC = FIRST_PAY_CYC + PAY_WORDS - 1;
  localparam logic [CYC_W-1:0] C_ROUTE = CYC_W'(ROUTE_CYC);
  localparam logic [CYC_W-1:0] C_HDR   = CYC_W'(HDR_CYC);
  localparam logic [CYC_W-1:0] C_PLO   = CYC_W'(FIRST_PAY_CYC);
  localparam logic [CYC_W-1:0] C_PHI   = CYC_W'(PAY_HI_CYC);
  localparam logic [CYC_W-1:0] C_PAR   = CYC_W'(FRAME_LEN - 1);
  localparam logic [CYC_W-1:0] C_RLO   = CYC_W'(FIRST_PAY_CYC - 1);
  localparam logic [CYC_W-1:0] C_RHI   = CYC_W'(PAY_HI_CYC - 1);

  logic [BUS_W-1:0] word_nxt;
  logic [BUS_W-1:0] data_q, data_d;
  logic [BUS_W-1:0] par_q, par_d;
  logic             oe_q;
  logic             par_en, par_seed, par_fold;

  // Payload read address runs one cycle ahead of the bus word.
  always_comb begin
    if (cyc_i >= C_RLO && cyc_i <= C_RHI)
      pay_idx_o = IDX_W'(cyc_i - C_RLO);
    else
      pay_idx_o = '0;
  end

  always_comb begin
    word_nxt = '0;
    par_seed = 1'b0;
    par_fold = 1'b0;
    if (cyc_nxt_i == C_ROUTE) begin
      word_nxt = route_i;
      par_seed = 1'b1;
    end else if (cyc_nxt_i == C_HDR) begin
      word_nxt = hdr_word_i;
      par_fold = 1'b1;
    end else if (cyc_nxt_i >= C_PLO && cyc_nxt_i <= C_PHI) begin
      word_nxt = pay_data_i;
      par_fold = 1'b1;
    end else if (cyc_nxt_i == C_PAR) begin
      word_nxt = par_q;
    end
  end

  always_comb begin
    par_en = drive_nxt_i && (par_seed || par_fold);
    par_d  = par_seed ? word_nxt : (par_q ^ word_nxt);
    data_d = drive_nxt_i ? word_nxt : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      oe_q   <= drive_nxt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      par_q <= '0;
    else if (par_en) par_q <= par_d;
  end

  assign bus_data_o = data_q;
  assign bus_oe_o   = oe_q;
endmodule

// File: rtl/cellbus_tx.sv
`timescale 1ns/1ps
module cellbus_tx #(
  parameter  int BUS_W     = 32,
  parameter  int NUM_DEV   = 16,
  parameter  int FRAME_LEN = 16,
  parameter  int PAY_WORDS = 12,
  localparam int ID_W      = $clog2(NUM_DEV),
  localparam int CYC_W     = $clog2(FRAME_LEN),
  localparam int IDX_W     = $clog2(PAY_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start_i,
  input  logic [ID_W-1:0]    dev_id_i,
  input  logic               cell_valid_i,
  input  logic [BUS_W-1:0]   route_i,
  input  logic [11:0]        vpi_i,
  input  logic [15:0]        vci_i,
  input  logic [2:0]         pti_i,
  input  logic               clp_i,
  output logic [IDX_W-1:0]   pay_idx_o,
  input  logic [BUS_W-1:0]   pay_data_i,
  input  logic               grant_valid_i,
  input  logic [ID_W-1:0]    grant_id_i,
  output logic [NUM_DEV-1:0] req_o,
  output logic [BUS_W-1:0]   bus_data_o,
  output logic               bus_oe_o,
  output logic               cell_done_o,
  output logic [CYC_W-1:0]   cyc_o
);
  logic [CYC_W-1:0] cyc_cur, cyc_nxt;
  logic [BUS_W-1:0] hdr_word;
  logic             drive_nxt;

  cb_frame_ctr #(.FRAME_LEN(FRAME_LEN)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (frame_start_i),
    .cyc_o     (cyc_cur),
    .cyc_nxt_o (cyc_nxt)
  );

  cb_hdr_pack #(.BUS_W(BUS_W)) u_hdr (
    .vpi_i  (vpi_i),
    .vci_i  (vci_i),
    .pti_i  (pti_i),
    .clp_i  (clp_i),
    .word_o (hdr_word)
  );

  cb_tx_ctrl #(.NUM_DEV(NUM_DEV), .FRAME_LEN(FRAME_LEN)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cyc_i         (cyc_cur),
    .cyc_nxt_i     (cyc_nxt),
    .dev_id_i      (dev_id_i),
    .cell_valid_i  (cell_valid_i),
    .grant_valid_i (grant_valid_i),
    .grant_id_i    (grant_id_i),
    .req_o         (req_o),
    .done_o        (cell_done_o),
    .drive_nxt_o   (drive_nxt)
  );

  cb_tx_dp #(.BUS_W(BUS_W), .FRAME_LEN(FRAME_LEN), .PAY_WORDS(PAY_WORDS)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_i       (cyc_cur),
    .cyc_nxt_i   (cyc_nxt),
    .drive_nxt_i (drive_nxt),
    .route_i     (route_i),
    .hdr_word_i  (hdr_word),
    .pay_data_i  (pay_data_i),
    .pay_idx_o   (pay_idx_o),
    .bus_data_o  (bus_data_o),
    .bus_oe_o    (bus_oe_o)
  );

  assign cyc_o = cyc_cur;
endmodule

// File: rtl/cb_tx_chk.sv
`timescale 1ns/1ps
module cb_tx_chk #(
  parameter  int BUS_W     = 32,
  parameter  int NUM_DEV   = 16,
  parameter  int FRAME_LEN = 16,
  localparam int CYC_W     = $clog2(FRAME_LEN)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start_i,
  input logic [NUM_DEV-1:0] req_o,
  input logic [BUS_W-1:0]   bus_data_o,
  input logic               bus_oe_o,
  input logic               cell_done_o,
  input logic [CYC_W-1:0]   cyc_o
);
  localparam logic [CYC_W-1:0] C_LAST = CYC_W'(FRAME_LEN - 1);

  assert_cycle_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_i |=> cyc_o == (($past(cyc_o) == C_LAST) ? '0 : $past(cyc_o) + CYC_W'(1)));

  assert_resync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> cyc_o == '0);

  assert_req_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o != '0) |-> (cyc_o == '0 && $countones(req_o) == 1));

  assert_oe_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |-> cyc_o != '0);

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> bus_data_o == '0);

  assert_oe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe_o && cyc_o != C_LAST && !frame_start_i) |=> bus_oe_o);

  assert_oe_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_o) |-> cyc_o == CYC_W'(1));

  assert_done_after_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cell_done_o |-> ($past(bus_oe_o) && cyc_o == '0 && req_o == '0));
endmodule

bind cellbus_tx cb_tx_chk #(.BUS_W(BUS_W), .NUM_DEV(NUM_DEV), .FRAME_LEN(FRAME_LEN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_start_i (frame_start_i),
  .req_o         (req_o),
  .bus_data_o    (bus_data_o),
  .bus_oe_o      (bus_oe_o),
  .cell_done_o   (cell_done_o),
  .cyc_o         (cyc_o)
);

// File: tb/cellbus_tx_tb.sv
`timescale 1ns/1ps
module cellbus_tx_tb;
  localparam int FL = 16;

  logic        clk = 1'b0;
  logic        rst_n, frame_start_i, cell_valid_i, clp_i, grant_valid_i;
  logic [3:0]  dev_id_i, grant_id_i, pay_idx_o, cyc_o;
  logic [31:0] route_i, pay_data_i, bus_data_o;
  logic [11:0] vpi_i;
  logic [15:0] vci_i, req_o;
  logic [2:0]  pti_i;
  logic        bus_oe_o, cell_done_o;
  int          seed;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pbyte(int b, int s);
    return 8'((b * 11 + s * 3 + 1) & 255);
  endfunction

  function automatic logic [31:0] pword(int k, int s);
    return {pbyte(4*k, s), pbyte(4*k+1, s), pbyte(4*k+2, s), pbyte(4*k+3, s)};
  endfunction

  function automatic logic [31:0] route_of(int s);
    return 32'((s + 1) * 32'h0101_0101) ^ 32'hC300_0000;
  endfunction

  function automatic logic [31:0] hdr_of(int s);
    return {12'((s * 37 + 5) & 4095), 16'((s * 1234 + 99) & 65535), 3'(s & 7), 1'(s & 1)};
  endfunction

  function automatic logic [31:0] exp_word(int c, int s);
    logic [31:0] p;
    if (c == 1) return route_of(s);
    if (c == 2) return hdr_of(s);
    if (c >= 3 && c <= 14) return pword(c - 3, s);
    p = '0;
    for (int j = 1; j <= 14; j++) p = p ^ exp_word(j, s);
    return p;
  endfunction

  assign route_i    = route_of(seed);
  assign vpi_i      = hdr_of(seed)[31:20];
  assign vci_i      = hdr_of(seed)[19:4];
  assign pti_i      = hdr_of(seed)[3:1];
  assign clp_i      = hdr_of(seed)[0];
  assign pay_data_i = pword(int'(pay_idx_o), seed);

  cellbus_tx u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i), .dev_id_i(dev_id_i),
    .cell_valid_i(cell_valid_i), .route_i(route_i), .vpi_i(vpi_i), .vci_i(vci_i),
    .pti_i(pti_i), .clp_i(clp_i), .pay_idx_o(pay_idx_o), .pay_data_i(pay_data_i),
    .grant_valid_i(grant_valid_i), .grant_id_i(grant_id_i), .req_o(req_o),
    .bus_data_o(bus_data_o), .bus_oe_o(bus_oe_o), .cell_done_o(cell_done_o), .cyc_o(cyc_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Runs one frame starting in cycle 0; abort_at < 0 means no re-alignment.
  task automatic run_frame(input int d, input bit ereq, input bit etx, input bit edone,
                           input bit gv, input int gid, input int abort_at);
    for (int c = 0; c < FL; c++) begin
      chk("R1 cycle number", 32'(cyc_o), 32'(c));
      chk("R2 request lines", 32'(req_o), (c == 0 && ereq) ? (32'(1) << d) : 32'(0));
      chk("R8 release pulse", 32'(cell_done_o), 32'(c == 0 && edone));
      chk("R4 output enable", 32'(bus_oe_o), 32'(etx && c != 0));
      if (etx && c == 15)
        chk("R7 parity word", bus_data_o, exp_word(c, seed));
      else if (etx && c != 0)
        chk("R5 cell word", bus_data_o, exp_word(c, seed));
      else
        chk("R4 idle data", bus_data_o, 32'(0));
      if (etx && c >= 2 && c <= 13)
        chk("R6 payload index", 32'(pay_idx_o), 32'(c - 2));
      grant_valid_i = gv && (c == 15);
      grant_id_i    = 4'(gid);
      frame_start_i = (c == abort_at);
      tick();
      grant_valid_i = 1'b0;
      if (c == abort_at) begin
        frame_start_i = 1'b0;
        return;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; frame_start_i = 1'b0; cell_valid_i = 1'b0;
    grant_valid_i = 1'b0; grant_id_i = '0; dev_id_i = '0; seed = 0;
    repeat (3) tick();
    chk("R10 reset req", 32'(req_o), 32'(0));
    chk("R10 reset oe", 32'(bus_oe_o), 32'(0));
    chk("R10 reset data", bus_data_o, 32'(0));
    chk("R10 reset done", 32'(cell_done_o), 32'(0));
    chk("R1 reset cycle", 32'(cyc_o), 32'(0));
    cell_valid_i = 1'b1;
    rst_n = 1'b1;
    tick();
    chk("R1 count after reset", 32'(cyc_o), 32'(1));
    frame_start_i = 1'b1;
    tick();
    frame_start_i = 1'b0;

    for (int d = 0; d < 16; d++) begin
      int nd;
      nd = (d + 1) % 16;
      if (d % 4 == 1)
        run_frame(d, 1, 0, 0, 1, (d + 5) % 16, -1);   // R3 grant to another station
      run_frame(d, 1, 0, 0, 1, d, -1);                 // request and matching grant
      if (d == 6) begin
        run_frame(d, 0, 1, 0, 0, 0, 5);                // R9 re-alignment mid-cell
        run_frame(d, 1, 0, 0, 1, d, -1);               // R9 requested again, no release
      end
      run_frame(d, 0, 1, 0, 1, d, -1);                 // R3 grant without request ignored
      dev_id_i = 4'(nd);
      seed     = nd;
      if (d == 9) cell_valid_i = 1'b0;
      run_frame(nd, 0, 0, 1, 1, nd, -1);               // R8 release, no request
      if (d == 9) begin
        cell_valid_i = 1'b1;
        run_frame(nd, 0, 0, 0, 1, nd, -1);             // R2 no cell, no request
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule